// File: doc/BRIEF.md
# Index-Addressed Interrupt Controller

This block collects 64 level-sensitive interrupt lines and drives a single CPU interrupt request. Each source carries two pieces of state: a global enable bit and a per-CPU mask bit. Software never reads, modifies and writes bit vectors to change them. Instead it writes the number of one source to a dedicated command address, and that one bit is set or cleared. A source raises the CPU request only while its line is high, it is enabled and it is not masked.

The bus is a simple word bus with an address, a write strobe with write data, and a read strobe. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe is sampled. The address space has two halves. The global half (address bit 8 low) holds the control word and the enable commands. The CPU half (address bit 8 high) holds the acknowledge word and the mask commands. The control word tells software how many sources exist. The acknowledge word gives the number of the lowest-numbered qualifying source, so software can service it and then mask it or remove its cause.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After a synchronous reset every enable bit is 0 and every mask bit is 1. With all source lines high, `cpu_irq` is 0 and the acknowledge word reads 0x3FF.
- R2: A write of value n (0 <= n < 64) to address 0x030 sets the enable bit of source n, and leaves every other bit unchanged.
- R3: A write of value n (0 <= n < 64) to address 0x034 clears the enable bit of source n, and leaves every other bit unchanged.
- R4: A write of value n (0 <= n < 64) to address 0x148 sets the mask bit of source n, so source n no longer requests the CPU.
- R5: A write of value n (0 <= n < 64) to address 0x14C clears the mask bit of source n.
- R6: A read of address 0x000 returns 0x0000_0100: the source count 64 in bits [11:2], with all other bits 0.
- R7: A read of address 0x144 returns, in bits [9:0], the lowest source number whose line is high, whose enable is 1 and whose mask is 0. Bits [31:10] are 0.
- R8: When no source qualifies, the acknowledge read returns 0x3FF.
- R9: `cpu_irq` is a register. It is 1 exactly one cycle after some source qualifies and 0 one cycle after none does.
- R10: Sources are level-sensitive. A source that stays high is reported again on every acknowledge read, because reading has no side effect. A source that drops stops qualifying without any bus write.
- R11: A command write whose 32-bit value is 64 or more changes no enable or mask bit.
- R12: A read of the command addresses (0x030, 0x034, 0x148, 0x14C) or of any unmapped address returns 0.
- R13: Writes to the control and acknowledge addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 9 | Byte address; bit 8 selects the CPU half |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (the source number for commands) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_src | input | 64 | Level-sensitive source lines |
| cpu_irq | output | 1 | Registered CPU interrupt request |

## Verification
The bench targets the following corner cases, and each would fail in a visible way:
- Several sources qualify at once, with some of them disabled or masked. Picking the highest number, or ignoring one of the two gates, returns the wrong acknowledge number.
- Both ends of the index range, 0 and 63, and the out-of-range values 64 and 0x401. An index decoded from only its low bits would flip the state of a real source.
- The idle code when nothing qualifies, and the pattern where only a disabled or masked source is high. Both must read 0x3FF and hold `cpu_irq` low.
- An acknowledge read repeated with the line held high, then the line dropped. A design that cleared pending state on the read, or latched edges, would report 0x3FF too early or the old number too late.
- The cycle in which `cpu_irq` rises. A combinational or doubly registered request would be seen one edge off.

// File: rtl/idx_irq_pkg.sv
package idx_irq_pkg;

    localparam int NUM_SRC_DEF = 64;
    localparam int ID_W        = 10;
    localparam int ADDR_W      = 9;
    localparam int DATA_W      = 32;

    localparam logic [ID_W-1:0] NO_SRC_ID = '1;

    // Command and status addresses (byte offsets, bit 8 selects CPU half)
    localparam logic [ADDR_W-1:0] A_CTRL    = 9'h000;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 9'h030;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 9'h034;
    localparam logic [ADDR_W-1:0] A_ACK     = 9'h144;
    localparam logic [ADDR_W-1:0] A_MSK_SET = 9'h148;
    localparam logic [ADDR_W-1:0] A_MSK_CLR = 9'h14C;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR
    } irq_op_e;

    typedef struct packed {
        irq_op_e         op;
        logic [ID_W-1:0] idx;
    } irq_cmd_t;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_CTRL,
        RD_ACK
    } rd_sel_e;

    // Control word: source count placed in bits [11:2]
    function automatic logic [DATA_W-1:0] ctrl_word(input int n);
        logic [DATA_W-1:0] w;
        w = '0;
        w[11:2] = 10'(n);
        return w;
    endfunction

endpackage

// File: rtl/idx_irq_decode.sv
module idx_irq_decode
    import idx_irq_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DEF
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output irq_cmd_t          cmd,
    output rd_sel_e           rd_sel
);

    logic in_range;

    // The full write value is compared, so 0x401 is out of range as well
    assign in_range = bus_wdata < DATA_W'(NUM_SRC);

    always_comb begin
        cmd.idx = bus_wdata[ID_W-1:0];
        cmd.op  = OP_NONE;
        if (bus_wr && in_range) begin
            case (bus_addr)
                A_EN_SET:  cmd.op = OP_EN_SET;
                A_EN_CLR:  cmd.op = OP_EN_CLR;
                A_MSK_SET: cmd.op = OP_MSK_SET;
                A_MSK_CLR: cmd.op = OP_MSK_CLR;
                default:   cmd.op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  rd_sel = RD_CTRL;
            A_ACK:   rd_sel = RD_ACK;
            default: rd_sel = RD_ZERO;
        endcase
    end

endmodule

// File: rtl/idx_irq_state.sv
module idx_irq_state
    import idx_irq_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  irq_cmd_t           cmd,
    input  logic [NUM_SRC-1:0] src,
    output logic [NUM_SRC-1:0] pend
);

    localparam int SEL_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] msk_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [ID_W-1:0] MY_ID = ID_W'(i);
        logic hit;
        assign hit = (cmd.idx == MY_ID);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i]  <= 1'b0;
                msk_q[i] <= 1'b1;
            end else if (hit) begin
                case (cmd.op)
                    OP_EN_SET:  en_q[i]  <= 1'b1;
                    OP_EN_CLR:  en_q[i]  <= 1'b0;
                    OP_MSK_SET: msk_q[i] <= 1'b1;
                    OP_MSK_CLR: msk_q[i] <= 1'b0;
                    default: ;
                endcase
            end
        end

        assign pend[i] = src[i] & en_q[i] & ~msk_q[i];
    end

    a_r2_enable_set: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_EN_SET |=> en_q[$past(cmd.idx[SEL_W-1:0])]);

    a_r3_enable_clear: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_EN_CLR |=> !en_q[$past(cmd.idx[SEL_W-1:0])]);

    a_r4_mask_set: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_MSK_SET |=> msk_q[$past(cmd.idx[SEL_W-1:0])]);

    a_r5_mask_clear: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_MSK_CLR |=> !msk_q[$past(cmd.idx[SEL_W-1:0])]);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        cmd.op == OP_NONE |=> (en_q == $past(en_q)) && (msk_q == $past(msk_q)));

endmodule

// File: rtl/idx_irq_prio.sv
module idx_irq_prio
    import idx_irq_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DEF
) (
    input  logic [NUM_SRC-1:0] vec,
    output logic               found,
    output logic [ID_W-1:0]    id
);

    // Scan downward so the lowest set index is the last one written
    always_comb begin
        found = 1'b0;
        id    = NO_SRC_ID;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                id    = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
    import idx_irq_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               cpu_irq
);

    localparam logic [DATA_W-1:0] CTRL_VAL = ctrl_word(NUM_SRC);

    irq_cmd_t           cmd;
    rd_sel_e            rd_sel;
    logic [NUM_SRC-1:0] pend;
    logic               ack_found;
    logic [ID_W-1:0]    ack_id;

    idx_irq_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .rd_sel    (rd_sel)
    );

    idx_irq_state #(.NUM_SRC(NUM_SRC)) u_state (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .src  (irq_src),
        .pend (pend)
    );

    idx_irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .vec   (pend),
        .found (ack_found),
        .id    (ack_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            cpu_irq   <= 1'b0;
        end else begin
            cpu_irq <= |pend;
            if (bus_rd) begin
                case (rd_sel)
                    RD_CTRL: bus_rdata <= CTRL_VAL;
                    RD_ACK:  bus_rdata <= DATA_W'(ack_id);
                    default: bus_rdata <= '0;
                endcase
            end
        end
    end

    a_r9_irq_follows_winner: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> $past(ack_found));

    a_r9_irq_drops: assert property (@(posedge clk) disable iff (rst)
        !cpu_irq |-> !$past(ack_found));

    a_r7_ack_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) && $past(rd_sel == RD_ACK) |-> bus_rdata[DATA_W-1:ID_W] == '0);

    a_r12_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) && $past(rd_sel == RD_ZERO) |-> bus_rdata == '0);

endmodule

// File: tb/test_idx_irq_ctrl.sv
module test_idx_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 64;

    localparam logic [8:0] A_CTRL    = 9'h000;
    localparam logic [8:0] A_EN_SET  = 9'h030;
    localparam logic [8:0] A_EN_CLR  = 9'h034;
    localparam logic [8:0] A_ACK     = 9'h144;
    localparam logic [8:0] A_MSK_SET = 9'h148;
    localparam logic [8:0] A_MSK_CLR = 9'h14C;
    localparam logic [31:0] IDLE     = 32'h3FF;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] en;
        logic [63:0] unm;
        logic [9:0]  exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{src: '1,                      en: 64'h20,  unm: 64'h20, exp: 10'd5},
        '{src: 64'h8000_0000_0000_0000, en: '1,      unm: '1,     exp: 10'd63},
        '{src: 64'h0000_0100_0010_0400, en: 64'h0000_0100_0010_0000, unm: '1, exp: 10'd20},
        '{src: 64'h88,                  en: '1,      unm: 64'h80, exp: 10'd7},
        '{src: 64'h3,                   en: 64'h2,   unm: 64'h1,  exp: 10'h3FF},
        '{src: 64'h0,                   en: '1,      unm: '1,     exp: 10'h3FF},
        '{src: 64'h8000_0000_0000_0001, en: '1,      unm: '1,     exp: 10'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        cpu_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_irq_ctrl i_idx_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NSRC; i++) begin
            wr(A_EN_CLR, 32'(i));
            wr(A_MSK_SET, 32'(i));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all lines high
        irq_src = '1;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq after reset", 32'(cpu_irq), 0);
        rd(A_ACK, d);
        check("R1 ack after reset", d, IDLE);

        // R6: control word
        rd(A_CTRL, d);
        check("R6 control word", d, 32'h100);

        // R5 then R1: unmask alone does nothing since enables are clear
        wr(A_MSK_CLR, 32'd3);
        rd(A_ACK, d);
        check("R1 enables cleared at reset", d, IDLE);

        // R2 and R9 timing
        wr(A_EN_SET, 32'd3);
        check("R9 irq not yet raised", 32'(cpu_irq), 0);
        @(negedge clk);
        check("R9 irq raised one cycle later", 32'(cpu_irq), 1);
        rd(A_ACK, d);
        check("R2 enable set source 3", d, 32'd3);

        // R1: source 4 is still masked from reset
        wr(A_EN_SET, 32'd4);
        wr(A_EN_CLR, 32'd3);
        rd(A_ACK, d);
        check("R3 clear 3, R1 source 4 still masked", d, IDLE);
        check("R9 irq low with nothing qualifying", 32'(cpu_irq), 0);

        // Table walk: R7, R8, R9
        for (int v = 0; v < NVEC; v++) begin
            clear_all();
            for (int i = 0; i < NSRC; i++) begin
                if (VECS[v].en[i])  wr(A_EN_SET, 32'(i));
                if (VECS[v].unm[i]) wr(A_MSK_CLR, 32'(i));
            end
            irq_src = VECS[v].src;
            @(negedge clk);
            @(negedge clk);
            rd(A_ACK, d);
            check($sformatf("R7/R8 vector %0d ack", v), d, 32'(VECS[v].exp));
            check($sformatf("R9 vector %0d irq", v), 32'(cpu_irq),
                  32'(VECS[v].exp != 10'h3FF));
        end

        // R11: out-of-range command values
        clear_all();
        irq_src = '1;
        for (int i = 0; i < NSRC; i++) wr(A_MSK_CLR, 32'(i));
        wr(A_EN_SET, 32'd64);
        wr(A_EN_SET, 32'h401);
        wr(A_EN_SET, 32'hFFFF_FFFF);
        rd(A_ACK, d);
        check("R11 enable index 64/0x401 ignored", d, IDLE);
        wr(A_EN_SET, 32'd2);
        wr(A_MSK_SET, 32'd64);
        wr(A_MSK_SET, 32'h402);
        rd(A_ACK, d);
        check("R11 mask index out of range ignored", d, 32'd2);
        wr(A_EN_CLR, 32'h402);
        rd(A_ACK, d);
        check("R11 clear index 0x402 ignored", d, 32'd2);

        // R13: writes to control and acknowledge change nothing
        wr(A_CTRL, 32'd2);
        wr(A_ACK, 32'd2);
        wr(A_ACK, 32'd0);
        rd(A_ACK, d);
        check("R13 ack after stray writes", d, 32'd2);
        rd(A_CTRL, d);
        check("R13 control after stray write", d, 32'h100);

        // R12: command and unmapped addresses read zero
        rd(A_EN_SET, d);
        check("R12 read enable set addr", d, 0);
        rd(A_EN_CLR, d);
        check("R12 read enable clear addr", d, 0);
        rd(A_MSK_SET, d);
        check("R12 read mask set addr", d, 0);
        rd(A_MSK_CLR, d);
        check("R12 read mask clear addr", d, 0);
        rd(9'h0F0, d);
        check("R12 read unmapped addr", d, 0);

        // R10: level behaviour, ack read has no side effect
        clear_all();
        irq_src = '0;
        irq_src[9] = 1'b1;
        wr(A_EN_SET, 32'd9);
        wr(A_MSK_CLR, 32'd9);
        rd(A_ACK, d);
        check("R10 first ack", d, 32'd9);
        rd(A_ACK, d);
        check("R10 repeated ack unchanged", d, 32'd9);
        check("R10 irq held while line high", 32'(cpu_irq), 1);
        irq_src[9] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 irq drops with the line", 32'(cpu_irq), 0);
        rd(A_ACK, d);
        check("R10 ack idle after line drop", d, IDLE);

        // R4: masking a held source stops the request
        irq_src[9] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 irq before mask", 32'(cpu_irq), 1);
        wr(A_MSK_SET, 32'd9);
        @(negedge clk);
        check("R4 irq after mask", 32'(cpu_irq), 0);
        rd(A_ACK, d);
        check("R4 ack after mask", d, IDLE);

        // R5 and R2 at the top index
        irq_src[63] = 1'b1;
        wr(A_EN_SET, 32'd63);
        wr(A_MSK_CLR, 32'd63);
        rd(A_ACK, d);
        check("R5 unmask index 63", d, 32'd63);

        finish_run();
    end

endmodule